// File: doc/BRIEF.md
# Frame packetizer with drop-tolerant data chunks

This block turns an 8-bit greyscale image held in a frame buffer into a series of payloads. Each payload is sized for one UDP datagram. The rectangle sent is either the whole image or a sub-window. A MAC with a single transmit buffer takes the stream. After a start pulse, the block first sends one descriptor packet. The descriptor announces the rectangle's size, how many data packets follow and how many pixel bytes they carry in total. The data packets follow, one after another.

Every data packet carries its own sequence number and the byte offset of its payload within the rectangle. A receiver can therefore place each chunk where it belongs and leave holes only where packets were lost. The block reads pixels through a simple read port with one cycle of latency. It writes bytes through a valid/ready interface and marks the final byte of each packet. An internal timer spaces the packets so that the MAC's single buffer has drained before the next packet begins.

Top module: `frame_packetizer`

## Requirements
- R1: After reset, `busy`, `out_valid` and `pix_rd` are low, and the block stays idle until `start` is seen high on a clock edge.
- R2: The first packet of a frame is 14 bytes, big-endian. Bytes 0-3 are ASCII "FRMB", bytes 4-5 the rectangle width, 6-7 its height, 8-9 the data packet count, and 10-13 the rectangle byte count (width times height). `out_last` is high on byte 13 only.
- R3: Every data packet begins with a 12-byte big-endian header. Bytes 0-3 are ASCII "DATA", 4-5 the sequence number, 6-7 the payload length, and 8-11 the byte offset of the payload within the rectangle.
- R4: The data packet count is ceil(bytes / 1460). Every data packet carries 1460 payload bytes, except the last, which carries the remainder. Sequence numbers run 0, 1, 2, and so on. Each offset equals the sum of the earlier payload lengths.
- R5: Payload bytes follow the rectangle in raster order: left to right, then top to bottom. For pixel (x, y) the block reads address y*IMG_W + x. It emits bits [19:12] of the 30-bit read word, which are the upper 8 bits of the green field in bits [19:10].
- R6: With `full_frame` high, the rectangle is the whole image, origin (0,0) and size IMG_W by IMG_H, and the window inputs are not used.
- R7: A window origin past the last column or row is moved to that last column or row. A size of 0 counts as 1. A window that reaches past the image edge is cut at the edge.
- R8: The window inputs and `full_frame` are sampled on the accepted start edge. Changes to them while the frame is being sent have no effect on its packets.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values. A byte transfers on a clock edge where both are high.
- R10: When a packet's last byte transfers in cycle t, the first byte of the next packet of the frame is presented in cycle t + PACE_CYCLES + 1, and not earlier.
- R11: `busy` rises on the accepted start and falls in the cycle after the last byte of the final data packet transfers. A `start` pulse seen while `busy` is high produces no extra packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin sending one frame (ignored while busy) |
| full_frame | input | 1 | Send the whole image instead of the window |
| win_x0 | input | $clog2(IMG_W+1) | Requested window left column |
| win_y0 | input | $clog2(IMG_H+1) | Requested window top row |
| win_w | input | $clog2(IMG_W+1) | Requested window width |
| win_h | input | $clog2(IMG_H+1) | Requested window height |
| busy | output | 1 | Frame in progress |
| pix_rd | output | 1 | Frame buffer read strobe |
| pix_addr | output | $clog2(IMG_W*IMG_H) | Frame buffer read address, y*IMG_W + x |
| pix_data | input | 30 | Read word, valid the cycle after `pix_rd` and held until the next read |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output byte valid |
| out_last | output | 1 | Final byte of the current packet |
| out_ready | input | 1 | Sink accepts the byte |

## Verification
A wrong window register or a wrong clipping result shows up first in the descriptor, within 16 cycles of start. It appears as a wrong width, height, count or size field. A stray raster counter shows in the payload of the first data packet that reaches the affected pixel, as the wrong grey value at a specific offset. A wrong sequence or offset register shows in bytes 4-11 of the next data header. A miscounted pacing timer shows at the very next packet boundary, as a gap that differs from PACE_CYCLES + 1. A wrong busy or idle state shows as a missing or extra packet, or as `busy` still high once the last packet has ended.

// File: rtl/fpk_pkg.sv
// Shared constants and helpers for the frame packetizer.
package fpk_pkg;
    localparam int MAX_PAYLOAD  = 1460;
    localparam int DESC_LEN     = 14;
    localparam int DATA_HDR_LEN = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_HDR,
        ST_FETCH,
        ST_PAY
    } fpk_state_t;

    // Grey value: top 8 bits of the green field held in bits [19:10].
    function automatic logic [7:0] grey_of(input logic [29:0] rgb);
        return rgb[19:12];
    endfunction
endpackage

// File: rtl/fpk_geometry.sv
// Window capture and clipping.
// On take, latches the rectangle: the whole image when full is set,
// otherwise the clipped window. Derives the byte count and the data packet count.
// Assumes IMG_W and IMG_H are at least 1.
module fpk_geometry #(
    parameter int IMG_W = 640,
    parameter int IMG_H = 480,
    parameter int MAX_PAYLOAD = 1460,
    localparam int XW = $clog2(IMG_W + 1),
    localparam int YW = $clog2(IMG_H + 1),
    localparam int NB = $clog2(IMG_W * IMG_H + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          full,
    input  logic [XW-1:0] req_x0,
    input  logic [YW-1:0] req_y0,
    input  logic [XW-1:0] req_w,
    input  logic [YW-1:0] req_h,
    output logic [XW-1:0] x0,
    output logic [YW-1:0] y0,
    output logic [XW-1:0] w,
    output logic [YW-1:0] h,
    output logic [NB-1:0] total_bytes,
    output logic [15:0]   pkt_count
);
    logic [XW-1:0] cx0, avail_w, rw, cw;
    logic [YW-1:0] cy0, avail_h, rh, ch;
    logic [31:0]   pk_wide;

    // Clip the requested window against the image edges.
    always_comb begin
        cx0     = (req_x0 >= XW'(IMG_W)) ? XW'(IMG_W - 1) : req_x0;
        cy0     = (req_y0 >= YW'(IMG_H)) ? YW'(IMG_H - 1) : req_y0;
        avail_w = XW'(IMG_W) - cx0;
        avail_h = YW'(IMG_H) - cy0;
        rw      = (req_w == '0) ? XW'(1) : req_w;
        rh      = (req_h == '0) ? YW'(1) : req_h;
        cw      = (rw > avail_w) ? avail_w : rw;
        ch      = (rh > avail_h) ? avail_h : rh;
    end

    // Latch the rectangle for the whole frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x0 <= '0;
            y0 <= '0;
            w  <= XW'(1);
            h  <= YW'(1);
        end else if (take) begin
            if (full) begin
                x0 <= '0;
                y0 <= '0;
                w  <= XW'(IMG_W);
                h  <= YW'(IMG_H);
            end else begin
                x0 <= cx0;
                y0 <= cy0;
                w  <= cw;
                h  <= ch;
            end
        end
    end

    // Byte count and packet count of the latched rectangle.
    always_comb begin
        total_bytes = NB'(w) * NB'(h);
        pk_wide     = (32'(total_bytes) + 32'(MAX_PAYLOAD - 1)) / 32'(MAX_PAYLOAD);
        pkt_count   = pk_wide[15:0];
    end
endmodule

// File: rtl/fpk_pacer.sv
// Inter-packet spacing timer.
// Loads on the last byte of a packet. Reports ready once PACE_CYCLES
// cycles have passed. It is ready out of reset.
module fpk_pacer #(
    parameter int PACE_CYCLES = 200000,
    localparam int PW = $clog2(PACE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic ready
);
    logic [PW-1:0] cnt;

    // Count down the remaining spacing cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= PW'(PACE_CYCLES - 1);
        else if (cnt != '0)
            cnt <= cnt - PW'(1);
    end

    assign ready = (cnt == '0);
endmodule

// File: rtl/fpk_raster.sv
// Raster address walker over the latched window.
// Init sets (x0, y0). Each step advances one pixel, wrapping at width w.
// Assumes w >= 1 and that init comes before the first step of a frame.
module fpk_raster #(
    parameter int IMG_W = 640,
    parameter int IMG_H = 480,
    localparam int XW = $clog2(IMG_W + 1),
    localparam int YW = $clog2(IMG_H + 1),
    localparam int AW = $clog2(IMG_W * IMG_H)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          step,
    input  logic [XW-1:0] x0,
    input  logic [YW-1:0] y0,
    input  logic [XW-1:0] w,
    output logic [AW-1:0] addr
);
    logic [XW-1:0] col;
    logic [AW-1:0] row_base;
    logic          pend;

    // A pending flag lets the row base pick up the freshly latched y0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col      <= '0;
            row_base <= '0;
            pend     <= 1'b0;
        end else if (init) begin
            col  <= '0;
            pend <= 1'b1;
        end else if (pend) begin
            row_base <= AW'(y0) * AW'(IMG_W);
            pend     <= 1'b0;
        end else if (step) begin
            if (col == w - XW'(1)) begin
                col      <= '0;
                row_base <= row_base + AW'(IMG_W);
            end else begin
                col <= col + XW'(1);
            end
        end
    end

    assign addr = row_base + AW'(x0) + AW'(col);
endmodule

// File: rtl/fpk_header_mux.sv
// Header byte selector for both packet kinds, big-endian fields.
module fpk_header_mux (
    input  logic        is_desc,
    input  logic [3:0]  idx,
    input  logic [15:0] width,
    input  logic [15:0] height,
    input  logic [15:0] count,
    input  logic [31:0] size,
    input  logic [15:0] seq,
    input  logic [15:0] len,
    input  logic [31:0] offset,
    output logic [7:0]  byte_out
);
    // Pick the byte at position idx of the active header.
    always_comb begin
        byte_out = 8'h00;
        if (is_desc) begin
            case (idx)
                4'd0:  byte_out = "F";
                4'd1:  byte_out = "R";
                4'd2:  byte_out = "M";
                4'd3:  byte_out = "B";
                4'd4:  byte_out = width[15:8];
                4'd5:  byte_out = width[7:0];
                4'd6:  byte_out = height[15:8];
                4'd7:  byte_out = height[7:0];
                4'd8:  byte_out = count[15:8];
                4'd9:  byte_out = count[7:0];
                4'd10: byte_out = size[31:24];
                4'd11: byte_out = size[23:16];
                4'd12: byte_out = size[15:8];
                4'd13: byte_out = size[7:0];
                default: byte_out = 8'h00;
            endcase
        end else begin
            case (idx)
                4'd0:  byte_out = "D";
                4'd1:  byte_out = "A";
                4'd2:  byte_out = "T";
                4'd3:  byte_out = "A";
                4'd4:  byte_out = seq[15:8];
                4'd5:  byte_out = seq[7:0];
                4'd6:  byte_out = len[15:8];
                4'd7:  byte_out = len[7:0];
                4'd8:  byte_out = offset[31:24];
                4'd9:  byte_out = offset[23:16];
                4'd10: byte_out = offset[15:8];
                4'd11: byte_out = offset[7:0];
                default: byte_out = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/frame_packetizer.sv
// Frame packetizer top.
// Sequences one descriptor packet followed by the data packets of the latched
// rectangle, with pacing between all packets. Assumes the frame buffer
// returns pix_data one cycle after pix_rd and holds it until the next read.
module frame_packetizer
    import fpk_pkg::*;
#(
    parameter int IMG_W = 640,
    parameter int IMG_H = 480,
    parameter int PACE_CYCLES = 200000,
    localparam int XW = $clog2(IMG_W + 1),
    localparam int YW = $clog2(IMG_H + 1),
    localparam int AW = $clog2(IMG_W * IMG_H),
    localparam int NB = $clog2(IMG_W * IMG_H + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          full_frame,
    input  logic [XW-1:0] win_x0,
    input  logic [YW-1:0] win_y0,
    input  logic [XW-1:0] win_w,
    input  logic [YW-1:0] win_h,
    output logic          busy,
    output logic          pix_rd,
    output logic [AW-1:0] pix_addr,
    input  logic [29:0]   pix_data,
    output logic [7:0]    out_data,
    output logic          out_valid,
    output logic          out_last,
    input  logic          out_ready
);
    fpk_state_t    st;
    logic          is_desc;
    logic [3:0]    hidx;
    logic [10:0]   plen;
    logic [10:0]   pcnt;
    logic [15:0]   seq;
    logic [NB-1:0] off;

    logic [XW-1:0] g_x0, g_w;
    logic [YW-1:0] g_y0, g_h;
    logic [NB-1:0] total;
    logic [15:0]   pkt_count;
    logic          pace_ready;
    logic [7:0]    hdr_byte;
    logic [NB-1:0] remaining;
    logic [10:0]   plen_next;
    logic          take, fire, hdr_end;

    assign take      = (st == ST_IDLE) && start;
    assign fire      = out_valid && out_ready;
    assign remaining = total - off;
    assign plen_next = (remaining > NB'(MAX_PAYLOAD)) ? 11'(MAX_PAYLOAD) : 11'(remaining);
    assign hdr_end   = is_desc ? (hidx == 4'(DESC_LEN - 1)) : (hidx == 4'(DATA_HDR_LEN - 1));

    fpk_geometry #(.IMG_W(IMG_W), .IMG_H(IMG_H), .MAX_PAYLOAD(MAX_PAYLOAD)) u_geom (
        .clk(clk), .rst_n(rst_n), .take(take), .full(full_frame),
        .req_x0(win_x0), .req_y0(win_y0), .req_w(win_w), .req_h(win_h),
        .x0(g_x0), .y0(g_y0), .w(g_w), .h(g_h),
        .total_bytes(total), .pkt_count(pkt_count)
    );

    fpk_pacer #(.PACE_CYCLES(PACE_CYCLES)) u_pacer (
        .clk(clk), .rst_n(rst_n), .load(fire && out_last), .ready(pace_ready)
    );

    fpk_raster #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_raster (
        .clk(clk), .rst_n(rst_n), .init(take), .step((st == ST_PAY) && fire),
        .x0(g_x0), .y0(g_y0), .w(g_w), .addr(pix_addr)
    );

    fpk_header_mux u_hdr (
        .is_desc(is_desc), .idx(hidx),
        .width(16'(g_w)), .height(16'(g_h)), .count(pkt_count), .size(32'(total)),
        .seq(seq), .len(16'(plen)), .offset(32'(off)),
        .byte_out(hdr_byte)
    );

    // Output byte, framing and read strobe.
    always_comb begin
        out_valid = (st == ST_HDR) || (st == ST_PAY);
        out_data  = (st == ST_PAY) ? grey_of(pix_data) : hdr_byte;
        out_last  = ((st == ST_HDR) && is_desc && hdr_end) ||
                    ((st == ST_PAY) && (pcnt == plen - 11'd1));
        pix_rd    = (st == ST_FETCH);
    end

    // Packet sequencer: descriptor, then header/payload pairs with gaps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            busy    <= 1'b0;
            is_desc <= 1'b0;
            hidx    <= '0;
            plen    <= '0;
            pcnt    <= '0;
            seq     <= '0;
            off     <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st      <= ST_GAP;
                        busy    <= 1'b1;
                        is_desc <= 1'b1;
                        seq     <= '0;
                        off     <= '0;
                    end
                end
                ST_GAP: begin
                    if (pace_ready) begin
                        st   <= ST_HDR;
                        hidx <= '0;
                        if (!is_desc)
                            plen <= plen_next;
                    end
                end
                ST_HDR: begin
                    if (fire) begin
                        if (hdr_end) begin
                            pcnt <= '0;
                            if (is_desc) begin
                                is_desc <= 1'b0;
                                st      <= ST_GAP;
                            end else begin
                                st <= ST_FETCH;
                            end
                        end else begin
                            hidx <= hidx + 4'd1;
                        end
                    end
                end
                ST_FETCH: st <= ST_PAY;
                ST_PAY: begin
                    if (fire) begin
                        if (out_last) begin
                            off <= off + NB'(plen);
                            seq <= seq + 16'd1;
                            if (off + NB'(plen) == total) begin
                                st   <= ST_IDLE;
                                busy <= 1'b0;
                            end else begin
                                st <= ST_GAP;
                            end
                        end else begin
                            pcnt <= pcnt + 11'd1;
                            st   <= ST_FETCH;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fpk_checker.sv
// Temporal checks on the packetizer ports, bound into every instance.
module fpk_checker #(
    parameter int PACE_CYCLES = 200000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       pix_rd,
    input logic [7:0] out_data,
    input logic       out_valid,
    input logic       out_last,
    input logic       out_ready
);
    logic [31:0] gap;
    logic        mid, have_prev;

    // Track packet boundaries and the cycles since the last packet ended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap       <= '0;
            mid       <= 1'b0;
            have_prev <= 1'b0;
        end else begin
            if (out_valid && out_ready && out_last) begin
                gap       <= '0;
                mid       <= 1'b0;
                have_prev <= 1'b1;
            end else begin
                if (gap != 32'hFFFF_FFFF)
                    gap <= gap + 32'd1;
                if (out_valid && out_ready)
                    mid <= 1'b1;
            end
        end
    end

    p_hold_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    p_last_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    p_pace_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !mid && have_prev) |-> (gap >= 32'(PACE_CYCLES)));

    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!out_valid && !pix_rd));

    p_busy_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(out_valid && out_ready && out_last)) |=> busy);

    p_no_read_while_presenting_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !pix_rd);
endmodule

bind frame_packetizer fpk_checker #(.PACE_CYCLES(PACE_CYCLES)) u_fpk_checker (
    .clk(clk), .rst_n(rst_n), .busy(busy), .pix_rd(pix_rd),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
    .out_ready(out_ready)
);

// File: tb/test_frame_packetizer.sv
// Directed bench for the frame packetizer: one task per scenario.
module test_frame_packetizer;
    localparam int W    = 144;
    localparam int H    = 130;
    localparam int PACE = 40;
    localparam int XW   = $clog2(W + 1);
    localparam int YW   = $clog2(H + 1);
    localparam int AW   = $clog2(W * H);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          full_frame = 1'b0;
    logic [XW-1:0] win_x0 = '0;
    logic [YW-1:0] win_y0 = '0;
    logic [XW-1:0] win_w = '0;
    logic [YW-1:0] win_h = '0;
    logic          busy, pix_rd, out_valid, out_last;
    logic [AW-1:0] pix_addr;
    logic [29:0]   pix_data = '0;
    logic [7:0]    out_data;
    logic          out_ready = 1'b1;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit stall = 1'b0;
    bit hold_bad = 1'b0;
    logic [7:0] rx [0:1535];

    frame_packetizer #(.IMG_W(W), .IMG_H(H), .PACE_CYCLES(PACE)) i_frame_packetizer (
        .clk(clk), .rst_n(rst_n), .start(start), .full_frame(full_frame),
        .win_x0(win_x0), .win_y0(win_y0), .win_w(win_w), .win_h(win_h),
        .busy(busy), .pix_rd(pix_rd), .pix_addr(pix_addr), .pix_data(pix_data),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
        .out_ready(out_ready)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] gval(input int a);
        return 8'((a * 37) + (a >> 7));
    endfunction

    // Frame buffer model: one cycle of read latency, data held between reads.
    always @(posedge clk)
        if (pix_rd)
            pix_data <= {~gval(int'(pix_addr)), 2'b01, gval(int'(pix_addr)), 2'b10,
                         gval(int'(pix_addr)) ^ 8'h5A, 2'b11};

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Collect one packet; flags any byte that changes while stalled.
    task automatic get_pkt(output int n, output int t_first, output int t_last);
        bit   was_stalled = 1'b0;
        logic [7:0] held = '0;
        n = 0;
        t_first = -1;
        t_last = -1;
        forever begin
            @(negedge clk);
            out_ready = stall ? ((cyc % 3) != 0) : 1'b1;
            #1;
            if (was_stalled && (!out_valid || out_data != held))
                hold_bad = 1'b1;
            was_stalled = 1'b0;
            if (out_valid) begin
                if (n == 0 && t_first < 0)
                    t_first = cyc;
                if (out_ready) begin
                    rx[n] = out_data;
                    n++;
                    if (out_last) begin
                        t_last = cyc;
                        break;
                    end
                end else begin
                    was_stalled = 1'b1;
                    held = out_data;
                end
            end
        end
        out_ready = 1'b1;
    endtask

    function automatic int be16(input int i);
        return {rx[i], rx[i+1]};
    endfunction
    function automatic int be32(input int i);
        return {rx[i], rx[i+1], rx[i+2], rx[i+3]};
    endfunction

    task automatic run_frame(input bit full, input int qx, input int qy, input int qw,
                             input int qh, input bit stall_on, input bit disturb,
                             input string req);
        int ex0, ey0, ew, eh, total, npk, n, tf, tl, prev;
        int cx, cy;
        if (full) begin
            ex0 = 0; ey0 = 0; ew = W; eh = H;
        end else begin
            cx = (qx >= W) ? W - 1 : qx;
            cy = (qy >= H) ? H - 1 : qy;
            ew = (qw == 0) ? 1 : qw;
            eh = (qh == 0) ? 1 : qh;
            if (ew > W - cx) ew = W - cx;
            if (eh > H - cy) eh = H - cy;
            ex0 = cx; ey0 = cy;
        end
        total = ew * eh;
        npk = (total + 1459) / 1460;
        stall = stall_on;
        hold_bad = 1'b0;
        @(negedge clk);
        full_frame = full;
        win_x0 = XW'(qx); win_y0 = YW'(qy); win_w = XW'(qw); win_h = YW'(qh);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R11", "busy after start", busy, 1);
        if (disturb) begin
            full_frame = ~full;
            win_x0 = XW'(3); win_y0 = YW'(2); win_w = XW'(7); win_h = YW'(5);
        end
        get_pkt(n, tf, tl);
        chk(n == 14, "R2", "descriptor length", n, 14);
        chk(be32(0) == 32'h46524D42, "R2", "descriptor tag", be32(0), 32'h46524D42);
        chk(be16(4) == ew && be16(6) == eh, req, "descriptor width*1000+height",
            be16(4) * 1000 + be16(6), ew * 1000 + eh);
        chk(be16(8) == npk, "R4", "descriptor packet count", be16(8), npk);
        chk(be32(10) == total, "R2", "descriptor byte size", be32(10), total);
        prev = tl;
        for (int k = 0; k < npk; k++) begin
            int plen, bad_at;
            if (disturb && k == 1) begin
                @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            get_pkt(n, tf, tl);
            plen = (total - k * 1460 > 1460) ? 1460 : total - k * 1460;
            chk(tf - prev == PACE + 1, "R10", "packet gap", tf - prev, PACE + 1);
            prev = tl;
            chk(be32(0) == 32'h44415441, "R3", "data tag", be32(0), 32'h44415441);
            chk(be16(4) == k, "R4", "sequence", be16(4), k);
            chk(be16(6) == plen && n == plen + 12, "R4", "payload length", n - 12, plen);
            chk(be32(8) == k * 1460, "R4", "offset", be32(8), k * 1460);
            bad_at = -1;
            for (int j = 0; j < plen && j + 12 < n; j++) begin
                int o, a;
                o = k * 1460 + j;
                a = (ey0 + o / ew) * W + ex0 + (o % ew);
                if (bad_at < 0 && rx[12 + j] != gval(a))
                    bad_at = j;
            end
            if (bad_at >= 0) begin
                int o2, a2;
                o2 = k * 1460 + bad_at;
                a2 = (ey0 + o2 / ew) * W + ex0 + (o2 % ew);
                chk(1'b0, "R5", "payload byte", rx[12 + bad_at], gval(a2));
            end else begin
                chk(1'b1, "R5", "payload", 0, 0);
            end
        end
        @(negedge clk);
        chk(busy == 1'b0, "R11", "busy after last packet", busy, 0);
        if (stall_on)
            chk(!hold_bad, "R9", "byte held while stalled", hold_bad, 0);
        if (disturb) begin
            bit seen = 1'b0;
            repeat (3 * PACE) begin
                @(negedge clk);
                if (out_valid || busy) seen = 1'b1;
            end
            chk(!seen, "R11", "no packet from start while busy", seen, 0);
        end
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        chk(!busy && !out_valid && !pix_rd, "R1", "idle after reset",
            {busy, out_valid, pix_rd}, 0);
        repeat (5) @(negedge clk);
        chk(!busy && !out_valid, "R1", "stays idle without start", {busy, out_valid}, 0);
    endtask

    task automatic t_full_frame;
        run_frame(1'b1, 17, 9, 3, 3, 1'b1, 1'b0, "R6");
    endtask

    task automatic t_window_128;
        run_frame(1'b0, 0, 0, 128, 128, 1'b0, 1'b0, "R4");
    endtask

    task automatic t_clip_edge;
        run_frame(1'b0, 80, 90, 128, 128, 1'b1, 1'b0, "R7");
    endtask

    task automatic t_clip_origin;
        run_frame(1'b0, 150, 140, 4, 0, 1'b0, 1'b0, "R7");
    endtask

    task automatic t_busy_ignore;
        run_frame(1'b0, 5, 5, 100, 20, 1'b0, 1'b1, "R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_full_frame();
        t_window_128();
        t_clip_edge();
        t_clip_origin();
        t_busy_ignore();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule